// File: doc/BRIEF.md
# LCD Frame Fetch Sequencer

This block sits between the register block of an LCD controller and its frame DMA. It controls the fetch of each frame at the frame level. When the controller is switched on, it checks that the buffer bounds are valid addresses. If the load mode calls for a palette, it streams the 256-entry palette out of the current buffer. After that, on every frame-start tick it works out how to fetch the coming frame.

For each frame it first reads the header word at the top of the buffer, unless the load mode carries no palette. It decodes the colour depth from bits 14:12 of that word and picks the offset at which pixel data begins. It then checks that the frame fits between the buffer's top and bottom. If it fits, the block hands a frame descriptor to the pixel engine: base address, bits per pixel, pixel format, line step, first line and line count. If it does not fit, it raises a sync error and asks the register block to drop its enable bit.

A single buffer or a ping-pong pair of buffers can be used. The block keeps the frame-done, palette-done and sync-error flags, the combined LCD interrupt, and three sticky DMA condition bits.

States: IDLE (switched off), CHECK (bound address test), PAL_LOAD (palette stream), READY (waiting for a tick), HDR_RD (header word read), EVAL (depth, fit and descriptor), HALT (stopped by an error until enable falls).

Transitions:
- IDLE to CHECK when enable rises.
- CHECK to HALT on a bad address.
- CHECK to PAL_LOAD when a palette is wanted, otherwise CHECK to READY.
- PAL_LOAD to READY after the last beat.
- READY to HDR_RD, or READY to EVAL in mode 2, on a tick outside mode 1.
- HDR_RD to EVAL on the read handshake.
- EVAL to READY when the frame is accepted or skipped, EVAL to HALT when it does not fit.
- HALT to IDLE, and every working state to IDLE, when enable falls.

Top module: `lcd_fetch_seq`

## Requirements
- R1: The depth code is bits 14:12 of the header word. Code 1 gives 2 bpp, code 2 gives 4 bpp, code 3 gives 8 bpp. Codes 4 to 7 give 16 bpp, with `frm_fmt16`=1 when `cfg_tft` is set and 0 (12-bit format) otherwise. Code 0 skips the frame: no descriptor, no condition bit.
- R2: When `cfg_load_mode` is not 2, enabling streams 256 sequential 16-bit reads from the current buffer top at byte addresses top+2k. Each beat is accepted on `rd_valid`&`rd_ready` and forwarded on `pal_we`/`pal_idx`=k/`pal_data`. `palette_done` rises after beat 255. A read request, once raised, stays up until accepted.
- R3: Pixel data begins at top+0x200 for depth codes 3 to 7 and at top+0x20 for codes 1 and 2. In load mode 2 it begins at the top with no header read, and the depth comes from the last header word captured.
- R4: If offset + width×height×bpp/8 exceeds (bottom − top) + 2, the block sets `sync_err`, pulses `enable_clr`, emits no descriptor and goes to HALT. Equality still fits.
- R5: An accepted frame sets the sticky `dma_cond` bit whose index is the current buffer (bit 0 or 1). It pulses `dma_irq` when `dma_irq_mask[0]` is set.
- R6: With `cfg_dual` set, `cur_buf` toggles after every accepted frame, so descriptors alternate between buffer 0 and buffer 1.
- R7: On enable, the addresses that must be valid are `addr_ok` bits 0 (buf0 top) and 1 (buf0 bottom), plus bits 2 (buf1 top) and 3 (buf1 bottom) only in dual mode. If one fails, the block sets `dma_cond[2]`, pulses `dma_irq` if `dma_irq_mask[1]` is set, pulses `enable_clr`, and reads nothing.
- R8: Enabling from IDLE sets `cur_buf` to 0 and clears `frame_done`, `palette_done` and `sync_err`.
- R9: Disabling from any working state sets `frame_done` unless the load mode is 1, and clears `sync_err`.
- R10: In load mode 1 frame ticks produce no frame.
- R11: With `sub_active` set, `sub_lines` gives `frm_first` when `sub_first_sel` is 1; otherwise it overrides `frm_lines`. Otherwise first is 0 and lines is height.
- R12: `frm_step` equals width×bpp/8 bytes, where width is `cfg_width_m1`+1.
- R13: `lcd_irq` = (`frame_done` & `cfg_irq_mask[0]`) | (`palette_done` & `cfg_irq_mask[1]`) | `sync_err`.
- R14: Frame ticks are ignored during a palette load, during HALT and while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Controller enable from the register block |
| cfg_load_mode | input | 2 | Palette/data load mode (1: no frames, 2: no palette) |
| cfg_tft | input | 1 | Active-matrix panel, selects 16-bit format at 16 bpp |
| cfg_dual | input | 1 | Ping-pong buffer mode |
| cfg_irq_mask | input | 2 | bit0 frame-done, bit1 palette-done interrupt enable |
| dma_irq_mask | input | 2 | bit0 frame condition, bit1 address-error interrupt enable |
| cfg_width_m1 | input | DIM_W | Width minus one, in pixels |
| cfg_height_m1 | input | DIM_W | Height minus one, in lines |
| sub_active | input | 1 | Subpanel mode on |
| sub_first_sel | input | 1 | Subpanel value is first line (1) or line count (0) |
| sub_lines | input | DIM_W | Subpanel line value |
| buf0_top | input | ADDR_W | Buffer 0 start address |
| buf0_bot | input | ADDR_W | Buffer 0 end address |
| buf1_top | input | ADDR_W | Buffer 1 start address |
| buf1_bot | input | ADDR_W | Buffer 1 end address |
| addr_ok | input | 4 | Validity of buf0 top/bottom, buf1 top/bottom |
| frame_tick | input | 1 | One-cycle frame-start pulse |
| rd_valid | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_ready | input | 1 | Read accepted; rd_data valid this cycle |
| rd_data | input | 16 | Read data |
| pal_we | output | 1 | Palette entry write strobe |
| pal_idx | output | PAL_AW | Palette entry index |
| pal_data | output | 16 | Palette entry value |
| frm_valid | output | 1 | One-cycle pulse: new descriptor |
| frm_base | output | ADDR_W | Pixel data start address |
| frm_bpp | output | 5 | Bits per pixel |
| frm_fmt16 | output | 1 | 16-bit format (1) or 12-bit (0) at 16 bpp |
| frm_step | output | DIM_W+2 | Line step in bytes |
| frm_first | output | DIM_W | First line drawn |
| frm_lines | output | DIM_W+1 | Number of lines |
| cur_buf | output | 1 | Current buffer index |
| frame_done | output | 1 | Frame-done flag |
| palette_done | output | 1 | Palette-loaded flag |
| sync_err | output | 1 | Buffer too small flag |
| lcd_irq | output | 1 | Combined LCD interrupt |
| dma_cond | output | 3 | Sticky DMA conditions: buf0 frame, buf1 frame, address error |
| dma_irq | output | 1 | One-cycle DMA interrupt pulse |
| enable_clr | output | 1 | One-cycle request to clear the enable bit |

## Verification
Each result has a fixed latency, and the bench drives and samples on falling edges so it can count edges exactly:

- The address-check result (condition bit, DMA pulse and enable-clear) appears two rising edges after enable is driven high.
- A frame descriptor appears three rising edges after the tick, through READY, HDR_RD and EVAL. In load mode 2 it appears after two.
- `sync_err` and `enable_clr` follow the same schedule as the descriptor.
- Disable flags update one edge after enable falls.

The checks either wait a margin past these edges before comparing held outputs, or count one-cycle pulses with a falling-edge monitor. The palette beats are compared with the expected index and data on every accepted beat while `rd_ready` stalls every other cycle.

// File: rtl/lcd_fetch_pkg.sv
package lcd_fetch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PAL_LOAD,
        ST_READY,
        ST_HDR_RD,
        ST_EVAL,
        ST_HALT
    } fetch_state_t;

    // Decoded header word
    typedef struct packed {
        logic       ok;       // depth code supported
        logic [2:0] shift;    // log2 of bits per pixel
        logic       big_hdr;  // full palette header in front of data
        logic       fmt16;    // 16-bit rather than 12-bit pixels
    } depth_info_t;

endpackage

// File: rtl/lcd_depth_decode.sv
module lcd_depth_decode
    import lcd_fetch_pkg::*;
(
    input  logic [2:0]  code,
    input  logic        tft,
    output depth_info_t info
);
    always_comb begin
        info = '0;
        unique case (code)
            3'd0: info = '0;
            3'd1: begin
                info.ok    = 1'b1;
                info.shift = 3'd1;
            end
            3'd2: begin
                info.ok    = 1'b1;
                info.shift = 3'd2;
            end
            3'd3: begin
                info.ok      = 1'b1;
                info.shift   = 3'd3;
                info.big_hdr = 1'b1;
            end
            default: begin
                info.ok      = 1'b1;
                info.shift   = 3'd4;
                info.big_hdr = 1'b1;
                info.fmt16   = tft;
            end
        endcase
    end
endmodule

// File: rtl/lcd_frame_geom.sv
module lcd_frame_geom #(
    parameter int ADDR_W    = 32,
    parameter int DIM_W     = 10,
    parameter int HDR_BIG   = 512,
    parameter int HDR_SMALL = 32,
    parameter int SLACK     = 2
) (
    input  logic [DIM_W-1:0]  width_m1,
    input  logic [DIM_W-1:0]  height_m1,
    input  logic [2:0]        shift,
    input  logic              hdr_present,
    input  logic              big_hdr,
    input  logic [ADDR_W-1:0] top,
    input  logic [ADDR_W-1:0] bot,
    output logic [ADDR_W-1:0] base,
    output logic [DIM_W+1:0]  step,
    output logic              fits
);
    localparam int W_W   = DIM_W + 1;
    localparam int WH_W  = 2 * W_W;
    localparam int CMP_W = ADDR_W + 2;

    logic [W_W-1:0]    w_px;
    logic [W_W-1:0]    h_ln;
    logic [WH_W-1:0]   wh;
    logic [WH_W+3:0]   wh_bits;
    logic [W_W+3:0]    w_bits;
    logic [ADDR_W-1:0] offset;
    logic [CMP_W-1:0]  need;
    logic [CMP_W-1:0]  room;

    always_comb begin
        w_px    = W_W'(width_m1) + W_W'(1);
        h_ln    = W_W'(height_m1) + W_W'(1);
        wh      = WH_W'(w_px) * WH_W'(h_ln);
        wh_bits = (WH_W+4)'(wh) << shift;
        w_bits  = (W_W+4)'(w_px) << shift;
        step    = w_bits[W_W+3:3];

        if (!hdr_present)
            offset = '0;
        else if (big_hdr)
            offset = ADDR_W'(HDR_BIG);
        else
            offset = ADDR_W'(HDR_SMALL);

        base = top + offset;
        need = CMP_W'(offset) + CMP_W'(wh_bits[WH_W+3:3]);
        room = CMP_W'(bot - top) + CMP_W'(SLACK);
        fits = (need <= room);
    end
endmodule

// File: rtl/lcd_fetch_seq.sv
module lcd_fetch_seq
    import lcd_fetch_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DIM_W     = 10,
    parameter int PAL_WORDS = 256,
    parameter int HDR_BIG   = 512,
    parameter int HDR_SMALL = 32,
    parameter int SLACK     = 2,
    localparam int PAL_AW   = $clog2(PAL_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [1:0]        cfg_load_mode,
    input  logic              cfg_tft,
    input  logic              cfg_dual,
    input  logic [1:0]        cfg_irq_mask,
    input  logic [1:0]        dma_irq_mask,
    input  logic [DIM_W-1:0]  cfg_width_m1,
    input  logic [DIM_W-1:0]  cfg_height_m1,
    input  logic              sub_active,
    input  logic              sub_first_sel,
    input  logic [DIM_W-1:0]  sub_lines,
    input  logic [ADDR_W-1:0] buf0_top,
    input  logic [ADDR_W-1:0] buf0_bot,
    input  logic [ADDR_W-1:0] buf1_top,
    input  logic [ADDR_W-1:0] buf1_bot,
    input  logic [3:0]        addr_ok,
    input  logic              frame_tick,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic [15:0]       rd_data,
    output logic              pal_we,
    output logic [PAL_AW-1:0] pal_idx,
    output logic [15:0]       pal_data,
    output logic              frm_valid,
    output logic [ADDR_W-1:0] frm_base,
    output logic [4:0]        frm_bpp,
    output logic              frm_fmt16,
    output logic [DIM_W+1:0]  frm_step,
    output logic [DIM_W-1:0]  frm_first,
    output logic [DIM_W:0]    frm_lines,
    output logic              cur_buf,
    output logic              frame_done,
    output logic              palette_done,
    output logic              sync_err,
    output logic              lcd_irq,
    output logic [2:0]        dma_cond,
    output logic              dma_irq,
    output logic              enable_clr
);
    localparam logic [1:0]        MODE_NO_FRAME = 2'd1;
    localparam logic [1:0]        MODE_NO_PAL   = 2'd2;
    localparam logic [PAL_AW-1:0] LAST_BEAT     = PAL_AW'(PAL_WORDS - 1);

    fetch_state_t state_q, state_d;

    logic              cur_q;
    logic [PAL_AW-1:0] beat_q;
    logic [15:0]       hdr_q;
    logic              frame_done_q, pal_done_q, sync_q;
    logic [2:0]        cond_q;
    logic              dma_irq_q, en_clr_q;
    logic              frm_valid_q, frm_fmt16_q;
    logic [ADDR_W-1:0] frm_base_q;
    logic [4:0]        frm_bpp_q;
    logic [DIM_W+1:0]  frm_step_q;
    logic [DIM_W-1:0]  frm_first_q;
    logic [DIM_W:0]    frm_lines_q;

    logic              rd_fire;
    logic              want_pal;
    logic              addr_bad;
    logic              working;
    logic [ADDR_W-1:0] top_cur, bot_cur;
    depth_info_t       dep;
    logic [ADDR_W-1:0] geo_base;
    logic [DIM_W+1:0]  geo_step;
    logic              geo_fits;

    assign want_pal = (cfg_load_mode != MODE_NO_PAL);
    assign top_cur  = cur_q ? buf1_top : buf0_top;
    assign bot_cur  = cur_q ? buf1_bot : buf0_bot;
    assign addr_bad = !addr_ok[0] || !addr_ok[1] ||
                      (cfg_dual && (!addr_ok[2] || !addr_ok[3]));
    assign working  = (state_q == ST_CHECK) || (state_q == ST_PAL_LOAD) ||
                      (state_q == ST_READY) || (state_q == ST_HDR_RD) ||
                      (state_q == ST_EVAL);

    lcd_depth_decode u_depth (
        .code (hdr_q[14:12]),
        .tft  (cfg_tft),
        .info (dep)
    );

    lcd_frame_geom #(
        .ADDR_W    (ADDR_W),
        .DIM_W     (DIM_W),
        .HDR_BIG   (HDR_BIG),
        .HDR_SMALL (HDR_SMALL),
        .SLACK     (SLACK)
    ) u_geom (
        .width_m1    (cfg_width_m1),
        .height_m1   (cfg_height_m1),
        .shift       (dep.shift),
        .hdr_present (want_pal),
        .big_hdr     (dep.big_hdr),
        .top         (top_cur),
        .bot         (bot_cur),
        .base        (geo_base),
        .step        (geo_step),
        .fits        (geo_fits)
    );

    // Read port
    assign rd_valid = (state_q == ST_PAL_LOAD) || (state_q == ST_HDR_RD);
    assign rd_addr  = (state_q == ST_PAL_LOAD) ?
                      top_cur + (ADDR_W'(beat_q) << 1) : top_cur;
    assign rd_fire  = rd_valid && rd_ready;
    assign pal_we   = (state_q == ST_PAL_LOAD) && rd_ready;
    assign pal_idx  = beat_q;
    assign pal_data = rd_data;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (working && !cfg_enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     if (cfg_enable) state_d = ST_CHECK;
                ST_CHECK: begin
                    if (addr_bad)      state_d = ST_HALT;
                    else if (want_pal) state_d = ST_PAL_LOAD;
                    else               state_d = ST_READY;
                end
                ST_PAL_LOAD: if (rd_fire && beat_q == LAST_BEAT) state_d = ST_READY;
                ST_READY: begin
                    if (frame_tick && cfg_load_mode != MODE_NO_FRAME)
                        state_d = want_pal ? ST_HDR_RD : ST_EVAL;
                end
                ST_HDR_RD:   if (rd_fire) state_d = ST_EVAL;
                ST_EVAL:     state_d = (dep.ok && !geo_fits) ? ST_HALT : ST_READY;
                ST_HALT:     if (!cfg_enable) state_d = ST_IDLE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // Flags, read bookkeeping and descriptor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q        <= 1'b0;
            beat_q       <= '0;
            hdr_q        <= '0;
            frame_done_q <= 1'b0;
            pal_done_q   <= 1'b0;
            sync_q       <= 1'b0;
            cond_q       <= '0;
            dma_irq_q    <= 1'b0;
            en_clr_q     <= 1'b0;
            frm_valid_q  <= 1'b0;
            frm_base_q   <= '0;
            frm_bpp_q    <= '0;
            frm_fmt16_q  <= 1'b0;
            frm_step_q   <= '0;
            frm_first_q  <= '0;
            frm_lines_q  <= '0;
        end else begin
            dma_irq_q   <= 1'b0;
            en_clr_q    <= 1'b0;
            frm_valid_q <= 1'b0;
            if (working && !cfg_enable) begin
                sync_q <= 1'b0;
                if (cfg_load_mode != MODE_NO_FRAME) frame_done_q <= 1'b1;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (cfg_enable) begin
                            cur_q        <= 1'b0;
                            beat_q       <= '0;
                            frame_done_q <= 1'b0;
                            pal_done_q   <= 1'b0;
                            sync_q       <= 1'b0;
                        end
                    end
                    ST_CHECK: begin
                        if (addr_bad) begin
                            cond_q[2] <= 1'b1;
                            dma_irq_q <= dma_irq_mask[1];
                            en_clr_q  <= 1'b1;
                        end
                    end
                    ST_PAL_LOAD: begin
                        if (rd_fire) begin
                            beat_q <= beat_q + PAL_AW'(1);
                            if (beat_q == '0)        hdr_q      <= rd_data;
                            if (beat_q == LAST_BEAT) pal_done_q <= 1'b1;
                        end
                    end
                    ST_HDR_RD: begin
                        if (rd_fire) hdr_q <= rd_data;
                    end
                    ST_EVAL: begin
                        if (dep.ok) begin
                            if (!geo_fits) begin
                                sync_q   <= 1'b1;
                                en_clr_q <= 1'b1;
                            end else begin
                                frm_valid_q   <= 1'b1;
                                frm_base_q    <= geo_base;
                                frm_bpp_q     <= 5'd1 << dep.shift;
                                frm_fmt16_q   <= dep.fmt16;
                                frm_step_q    <= geo_step;
                                frm_first_q   <= (sub_active && sub_first_sel) ? sub_lines : '0;
                                frm_lines_q   <= (sub_active && !sub_first_sel) ?
                                                 (DIM_W+1)'(sub_lines) :
                                                 (DIM_W+1)'(cfg_height_m1) + (DIM_W+1)'(1);
                                cond_q[cur_q] <= 1'b1;
                                dma_irq_q     <= dma_irq_mask[0];
                                if (cfg_dual) cur_q <= ~cur_q;
                            end
                        end
                    end
                    ST_READY, ST_HALT: ;
                    default: ;
                endcase
            end
        end
    end

    assign frm_valid    = frm_valid_q;
    assign frm_base     = frm_base_q;
    assign frm_bpp      = frm_bpp_q;
    assign frm_fmt16    = frm_fmt16_q;
    assign frm_step     = frm_step_q;
    assign frm_first    = frm_first_q;
    assign frm_lines    = frm_lines_q;
    assign cur_buf      = cur_q;
    assign frame_done   = frame_done_q;
    assign palette_done = pal_done_q;
    assign sync_err     = sync_q;
    assign dma_cond     = cond_q;
    assign dma_irq      = dma_irq_q;
    assign enable_clr   = en_clr_q;
    assign lcd_irq      = (frame_done_q & cfg_irq_mask[0]) |
                          (pal_done_q & cfg_irq_mask[1]) | sync_q;

endmodule

// File: rtl/lcd_fetch_seq_chk.sv
module lcd_fetch_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_enable,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic       frm_valid,
    input logic [4:0] frm_bpp,
    input logic       sync_err,
    input logic       enable_clr,
    input logic       lcd_irq,
    input logic [2:0] dma_cond
);
    AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && cfg_enable) |=> rd_valid); // R2

    AST_NO_FRAME_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> !rd_valid); // R14

    AST_BPP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> ($onehot(frm_bpp) && !frm_bpp[0])); // R1

    AST_SYNC_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err) |-> enable_clr); // R4

    AST_SYNC_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> lcd_irq); // R13

    AST_COND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((dma_cond & $past(dma_cond)) == $past(dma_cond))); // R5
endmodule

bind lcd_fetch_seq lcd_fetch_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .frm_valid  (frm_valid),
    .frm_bpp    (frm_bpp),
    .sync_err   (sync_err),
    .enable_clr (enable_clr),
    .lcd_irq    (lcd_irq),
    .dma_cond   (dma_cond)
);

// File: tb/lcd_fetch_seq_tb_top.sv
module lcd_fetch_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int DIM_W  = 10;
    localparam logic [31:0] TOP0 = 32'h0001_0000;
    localparam logic [31:0] TOP1 = 32'h0002_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b0;
    logic [1:0] cfg_load_mode = 2'd0;
    logic cfg_tft = 1'b0, cfg_dual = 1'b0;
    logic [1:0] cfg_irq_mask = 2'b00, dma_irq_mask = 2'b00;
    logic [DIM_W-1:0] cfg_width_m1 = 10'd15, cfg_height_m1 = 10'd7;
    logic sub_active = 1'b0, sub_first_sel = 1'b0;
    logic [DIM_W-1:0] sub_lines = '0;
    logic [ADDR_W-1:0] buf0_top = TOP0, buf0_bot = TOP0 + 32'h1000;
    logic [ADDR_W-1:0] buf1_top = TOP1, buf1_bot = TOP1 + 32'h1000;
    logic [3:0] addr_ok = 4'hF;
    logic frame_tick = 1'b0;
    logic rd_valid, rd_ready = 1'b1;
    logic [ADDR_W-1:0] rd_addr;
    logic [15:0] rd_data;
    logic pal_we;
    logic [7:0] pal_idx;
    logic [15:0] pal_data;
    logic frm_valid, frm_fmt16;
    logic [ADDR_W-1:0] frm_base;
    logic [4:0] frm_bpp;
    logic [DIM_W+1:0] frm_step;
    logic [DIM_W-1:0] frm_first;
    logic [DIM_W:0] frm_lines;
    logic cur_buf, frame_done, palette_done, sync_err, lcd_irq, dma_irq, enable_clr;
    logic [2:0] dma_cond;

    logic [15:0] hdr0 = 16'h3000, hdr1 = 16'h3000;
    logic stall = 1'b0;
    int n_chk = 0, n_fail = 0;
    int n_frm = 0, n_pal = 0, n_dirq = 0, n_clr = 0, pal_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: header words at buffer tops, address-derived data elsewhere
    assign rd_data = (rd_addr == buf0_top) ? hdr0 :
                     (rd_addr == buf1_top) ? hdr1 : rd_addr[16:1];

    always @(posedge clk) rd_ready <= stall ? ~rd_ready : 1'b1;

    lcd_fetch_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_load_mode(cfg_load_mode),
        .cfg_tft(cfg_tft), .cfg_dual(cfg_dual), .cfg_irq_mask(cfg_irq_mask),
        .dma_irq_mask(dma_irq_mask), .cfg_width_m1(cfg_width_m1), .cfg_height_m1(cfg_height_m1),
        .sub_active(sub_active), .sub_first_sel(sub_first_sel), .sub_lines(sub_lines),
        .buf0_top(buf0_top), .buf0_bot(buf0_bot), .buf1_top(buf1_top), .buf1_bot(buf1_bot),
        .addr_ok(addr_ok), .frame_tick(frame_tick), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_data(rd_data), .pal_we(pal_we), .pal_idx(pal_idx),
        .pal_data(pal_data), .frm_valid(frm_valid), .frm_base(frm_base), .frm_bpp(frm_bpp),
        .frm_fmt16(frm_fmt16), .frm_step(frm_step), .frm_first(frm_first), .frm_lines(frm_lines),
        .cur_buf(cur_buf), .frame_done(frame_done), .palette_done(palette_done),
        .sync_err(sync_err), .lcd_irq(lcd_irq), .dma_cond(dma_cond), .dma_irq(dma_irq),
        .enable_clr(enable_clr)
    );

    // pulse monitor, samples away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (frm_valid)  n_frm++;
            if (dma_irq)    n_dirq++;
            if (enable_clr) n_clr++;
            if (pal_we) begin
                if (pal_idx !== 8'(n_pal) ||
                    pal_data !== ((pal_idx == 8'd0) ? hdr0 : 16'h8000 + 16'(pal_idx)))
                    pal_bad++;
                n_pal++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) frame_tick = 1'b1;
        @(negedge clk) frame_tick = 1'b0;
        cyc(4);
    endtask

    task automatic wait_pal();
        for (int i = 0; i < 700 && !palette_done; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R13 irq low after reset", 32'(lcd_irq), 0);
        chk("R2 no read after reset", 32'(rd_valid), 0);
        chk("R5 cond clear after reset", 32'(dma_cond), 0);
        chk("R8 buffer 0 after reset", 32'(cur_buf), 0);
    endtask

    task automatic t_addr_check();
        int clr0;
        clr0 = n_clr;
        cfg_load_mode = 2'd2; cfg_dual = 1'b0; addr_ok = 4'b0011;
        cfg_enable = 1'b1;
        cyc(3);
        chk("R7 second pair ignored in single mode", 32'(dma_cond[2]), 0);
        chk("R7 no enable clear when valid", 32'(n_clr - clr0), 0);
        @(negedge clk) cfg_enable = 1'b0;
        cyc(1);
        chk("R9 frame_done set on disable mode 2", 32'(frame_done), 1);
        cfg_dual = 1'b1; dma_irq_mask = 2'b10;
        cfg_enable = 1'b1;
        cyc(2);
        chk("R7 address error condition bit 2", 32'(dma_cond[2]), 1);
        chk("R7 dma irq pulse on address error", 32'(dma_irq), 1);
        chk("R7 enable clear pulse", 32'(enable_clr), 1);
        cyc(2);
        chk("R7 no read after address error", 32'(n_pal), 0);
        cfg_enable = 1'b0; cfg_dual = 1'b0; addr_ok = 4'hF;
        cyc(2);
    endtask

    task automatic t_palette();
        int f0;
        f0 = n_frm;
        cfg_load_mode = 2'd0; cfg_irq_mask = 2'b10; dma_irq_mask = 2'b01; stall = 1'b1;
        cfg_enable = 1'b1;
        cyc(2);
        chk("R8 frame_done cleared on enable", 32'(frame_done), 0);
        cyc(40);
        @(negedge clk) frame_tick = 1'b1;
        @(negedge clk) frame_tick = 1'b0;
        wait_pal();
        stall = 1'b0;
        cyc(3);
        chk("R2 palette beat count", 32'(n_pal), 256);
        chk("R2 palette beat index and data", 32'(pal_bad), 0);
        chk("R2 palette_done", 32'(palette_done), 1);
        chk("R14 tick during load ignored", 32'(n_frm - f0), 0);
        chk("R13 irq from palette_done", 32'(lcd_irq), 1);
    endtask

    task automatic t_frame8();
        int f0, d0;
        f0 = n_frm; d0 = n_dirq;
        hdr0 = 16'h3000;
        tick();
        chk("R5 one descriptor", 32'(n_frm - f0), 1);
        chk("R1 code 3 is 8 bpp", 32'(frm_bpp), 8);
        chk("R3 base after big header", frm_base, TOP0 + 32'h200);
        chk("R12 step 16 px at 8 bpp", 32'(frm_step), 16);
        chk("R11 default lines", 32'(frm_lines), 8);
        chk("R5 condition bit 0", 32'(dma_cond[0]), 1);
        chk("R5 dma irq pulse", 32'(n_dirq - d0), 1);
        chk("R6 single mode keeps buffer", 32'(cur_buf), 0);
    endtask

    task automatic t_depths();
        int f0;
        hdr0 = 16'h1000; tick();
        chk("R1 code 1 is 2 bpp", 32'(frm_bpp), 2);
        chk("R3 small header offset", frm_base, TOP0 + 32'h20);
        chk("R12 step at 2 bpp", 32'(frm_step), 4);
        hdr0 = 16'h2abc; tick();
        chk("R1 code 2 is 4 bpp", 32'(frm_bpp), 4);
        chk("R12 step at 4 bpp", 32'(frm_step), 8);
        hdr0 = 16'h7000; cfg_tft = 1'b0; tick();
        chk("R1 code 7 is 16 bpp", 32'(frm_bpp), 16);
        chk("R1 12-bit format without tft", 32'(frm_fmt16), 0);
        chk("R3 big header for code 7", frm_base, TOP0 + 32'h200);
        hdr0 = 16'h4000; cfg_tft = 1'b1; tick();
        chk("R1 16-bit format with tft", 32'(frm_fmt16), 1);
        chk("R12 step at 16 bpp", 32'(frm_step), 32);
        cfg_tft = 1'b0;
        f0 = n_frm;
        hdr0 = 16'h8fff; tick();
        chk("R1 code 0 skips frame", 32'(n_frm - f0), 0);
        hdr0 = 16'h3000;
    endtask

    task automatic t_subpanel();
        sub_active = 1'b1; sub_first_sel = 1'b1; sub_lines = 10'd5; tick();
        chk("R11 first line from subpanel", 32'(frm_first), 5);
        chk("R11 lines kept with first select", 32'(frm_lines), 8);
        sub_first_sel = 1'b0; sub_lines = 10'd3; tick();
        chk("R11 lines override", 32'(frm_lines), 3);
        chk("R11 first zero on override", 32'(frm_first), 0);
        sub_active = 1'b0; tick();
        chk("R11 inactive subpanel", 32'(frm_lines), 8);
    endtask

    task automatic t_fit();
        int f0, c0;
        buf0_bot = TOP0 + 32'd638; // need = 0x200 + 128 = 640 = size + 2
        f0 = n_frm; tick();
        chk("R4 exact fit accepted", 32'(n_frm - f0), 1);
        buf0_bot = TOP0 + 32'd637;
        f0 = n_frm; c0 = n_clr; tick();
        chk("R4 sync error set", 32'(sync_err), 1);
        chk("R4 enable clear pulse", 32'(n_clr - c0), 1);
        chk("R4 no descriptor when too small", 32'(n_frm - f0), 0);
        chk("R13 irq from sync error", 32'(lcd_irq), 1);
        f0 = n_frm; tick();
        chk("R14 tick in halt ignored", 32'(n_frm - f0), 0);
        cfg_enable = 1'b0; buf0_bot = TOP0 + 32'h1000;
        cyc(2);
    endtask

    task automatic t_modes();
        int f0, p0;
        p0 = n_pal;
        cfg_load_mode = 2'd2; cfg_enable = 1'b1;
        cyc(4);
        chk("R8 sync error cleared on enable", 32'(sync_err), 0);
        chk("R10 no palette in mode 2", 32'(n_pal - p0), 0);
        hdr0 = 16'h1000; // not read in mode 2; depth stays from held word 0x3000
        tick();
        chk("R3 mode 2 base at top", frm_base, TOP0);
        chk("R3 mode 2 keeps held depth", 32'(frm_bpp), 8);
        hdr0 = 16'h3000;
        cfg_load_mode = 2'd1;
        f0 = n_frm; tick();
        chk("R10 mode 1 draws nothing", 32'(n_frm - f0), 0);
        @(negedge clk) cfg_enable = 1'b0;
        cyc(1);
        chk("R9 no frame_done in mode 1", 32'(frame_done), 0);
        cyc(2);
    endtask

    task automatic t_dual();
        cfg_load_mode = 2'd2; cfg_dual = 1'b1; cfg_enable = 1'b1;
        cyc(4);
        tick();
        chk("R6 first frame from buffer 0", frm_base, TOP0);
        chk("R6 toggled to buffer 1", 32'(cur_buf), 1);
        tick();
        chk("R6 second frame from buffer 1", frm_base, TOP1);
        chk("R5 condition bit 1", 32'(dma_cond[1]), 1);
        tick();
        chk("R6 third frame back to buffer 0", frm_base, TOP0);
        chk("R6 now on buffer 1", 32'(cur_buf), 1);
        @(negedge clk) cfg_enable = 1'b0;
        cyc(1);
        chk("R9 frame_done on disable", 32'(frame_done), 1);
        cfg_enable = 1'b1;
        cyc(2);
        chk("R8 buffer reset to 0 on enable", 32'(cur_buf), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_addr_check();
        t_palette();
        t_frame8();
        t_depths();
        t_subpanel();
        t_fit();
        t_modes();
        t_dual();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule